// File: doc/BRIEF.md
# Video Display Processor Host Port

This block sits between a 16-bit host processor bus and the VRAM port of a tile-based video display processor. The host reaches it through four decoded addresses: a data read port, a status read port, a data write port and a command port. The device's 8-bit interface rides on the most significant byte lane of the host data bus. Nothing on the low lane is ever used or driven.

Every command takes two bytes on the command port, low byte first. The first byte is always held. The two top bits of the second byte choose what happens next:
- Load the 14-bit VRAM pointer for reading. This also prefetches the addressed byte.
- Load the 14-bit VRAM pointer for writing.
- Write one of eight write-only control registers.
- Do nothing, for the illegal code.

After setup, data bytes pass through the data ports. The pointer advances after every data access. Reads are served from a read-ahead latch, which is refilled from VRAM after each read. The control registers drive two things on the display side: a blanking output, and an optional programmable signed pointer step.

Top module: `vdpHostPort`

## Requirements
- R1: Only four host addresses reach the block. Read data is at 0x8800, read status at 0x8802, write data at 0x8C00 and command at 0x8C02. A read from any other address, including a write-only port, leaves `hostRdOe` low and `hostRdData` at zero and does not move the pointer. A write to any other address changes nothing.
- R2: Only host data bits 15:8 carry the device byte. On reads, bits 7:0 of `hostRdData` are zero. On writes, bits 7:0 are ignored.
- R3: The first command byte becomes pointer bits 7:0. Bits 5:0 of the second byte become pointer bits 13:8.
- R4: When bits 7:6 of the second byte are 01, the pointer is loaded for writing. Each data-port write then stores its byte at the pointer, and the pointer advances.
- R5: When bits 7:6 of the second byte are 00, the pointer is loaded and the byte there is fetched into a read-ahead latch, after which the pointer advances. Each data-port read returns the latch and fetches the next byte. The host must leave at least one idle cycle after the second command byte.
- R6: When bits 7:6 of the second byte are 10, the first byte is written into control register n, where n is bits 2:0 of the second byte. Register n appears on `ctrlRegs[8n+7:8n]`. The pointer does not change.
- R7: Command code 11 changes no register and does not change the pointer.
- R8: The pointer wraps from 0x3FFF to 0x0000.
- R9: A status read, a data read or a data write returns the command sequencer to expecting a first byte.
- R10: A status read returns `statusIn` on bits 15:8.
- R11: `blankOut` is high while bit 6 of register 1 is 0. VRAM and register access work the same whether or not the display is blanked.
- R12: While bit 1 of register 0 is set, the pointer advances by register 7 read as a signed byte. Otherwise it advances by +1. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 16 | Host address |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostWrData | input | 16 | Host write data, device byte on bits 15:8 |
| hostRdData | output | 16 | Host read data, device byte on bits 15:8 |
| hostRdOe | output | 1 | High while the block drives the host bus |
| statusIn | input | 8 | Status byte from the display side |
| vramAddr | output | 14 | VRAM address |
| vramRdEn | output | 1 | VRAM read request, data due next cycle |
| vramRdData | input | 8 | VRAM read data |
| vramWrEn | output | 1 | VRAM write strobe |
| vramWrData | output | 8 | VRAM write data |
| ctrlRegs | output | 64 | Control register bank, register n at bits 8n+7:8n |
| blankOut | output | 1 | Display blanked to backdrop |

## Verification
The bench first runs a write burst. It then reads the same bytes back through a read setup. A design that skipped the prefetch, or returned the latch before refilling it, would come back one byte out of step. Register writes and the illegal code sit in the middle of a read stream, so a design that reloaded or cleared the pointer on either would return bytes from the wrong address. Other tests cover:
- Wrap at the top of the 14-bit range.
- A negative programmed step.
- A half-sent command broken by a status read or a data write. A sequencer that failed to resynchronise would treat the next first byte as a second byte and write to the wrong address.
- Reads aimed at write-only or unmapped addresses, which must not drive the bus or move the pointer.

// File: rtl/vdpHostPkg.sv
`timescale 1ns/1ps
package vdpHostPkg;

  // Decoded host accesses, at most one per cycle
  typedef struct packed {
    logic dataRd;
    logic statRd;
    logic dataWr;
    logic cmdWr;
  } hostStrobes_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadLow;    // hold first command byte
    logic loadPtr;    // load pointer from held byte and second byte
    logic regWr;      // write a control register
    logic vramRd;     // fetch at pointer
    logic vramWr;     // store at pointer
    logic advance;    // step the pointer
    logic capture;    // fetched byte is on vramRdData this cycle
    logic driveData;  // host reads the data port
    logic driveStat;  // host reads the status port
  } dpCtrl_t;

  typedef enum logic [1:0] {
    CMD_RD_SETUP = 2'b00,
    CMD_WR_SETUP = 2'b01,
    CMD_REG_WR   = 2'b10,
    CMD_ILLEGAL  = 2'b11
  } cmdType_e;

endpackage

// File: rtl/vdpHostDecode.sv
`timescale 1ns/1ps
module vdpHostDecode
  import vdpHostPkg::*;
#(
  parameter int          HOST_AW      = 16,
  parameter logic [15:0] RD_DATA_ADDR = 16'h8800,
  parameter logic [15:0] RD_STAT_ADDR = 16'h8802,
  parameter logic [15:0] WR_DATA_ADDR = 16'h8C00,
  parameter logic [15:0] WR_CMD_ADDR  = 16'h8C02
) (
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostRd,
  input  logic               hostWr,
  output hostStrobes_t       strb
);

  always_comb begin
    strb.dataRd = hostRd && (hostAddr == RD_DATA_ADDR[HOST_AW-1:0]);
    strb.statRd = hostRd && (hostAddr == RD_STAT_ADDR[HOST_AW-1:0]);
    strb.dataWr = hostWr && (hostAddr == WR_DATA_ADDR[HOST_AW-1:0]);
    strb.cmdWr  = hostWr && (hostAddr == WR_CMD_ADDR[HOST_AW-1:0]);
  end

  // R1: a single address selects at most one port
  always_comb begin
    p_one_port_r1: assert ($onehot0({strb.dataRd, strb.statRd, strb.dataWr, strb.cmdWr}));
  end

endmodule

// File: rtl/vdpHostCtrl.sv
`timescale 1ns/1ps
module vdpHostCtrl
  import vdpHostPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  hostStrobes_t strb,
  input  logic [1:0]   cmdBits,
  output dpCtrl_t      ctl
);

  logic secondByte;
  logic setupPend;
  logic capturePend;
  logic fetch;
  cmdType_e cmdType;

  assign cmdType = cmdType_e'(cmdBits);
  // a pending read setup yields to a same-cycle data write
  assign fetch   = strb.dataRd || (setupPend && !strb.dataWr);

  always_comb begin
    ctl           = '0;
    ctl.driveData = strb.dataRd;
    ctl.driveStat = strb.statRd;
    if (strb.cmdWr) begin
      if (!secondByte) begin
        ctl.loadLow = 1'b1;
      end else begin
        unique case (cmdType)
          CMD_RD_SETUP: ctl.loadPtr = 1'b1;
          CMD_WR_SETUP: ctl.loadPtr = 1'b1;
          CMD_REG_WR:   ctl.regWr   = 1'b1;
          default:      ;
        endcase
      end
    end
    ctl.vramWr  = strb.dataWr;
    ctl.vramRd  = fetch;
    ctl.advance = strb.dataWr || fetch;
    ctl.capture = capturePend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secondByte  <= 1'b0;
      setupPend   <= 1'b0;
      capturePend <= 1'b0;
    end else begin
      if (strb.cmdWr)
        secondByte <= !secondByte;
      else if (strb.dataRd || strb.statRd || strb.dataWr)
        secondByte <= 1'b0;

      if (strb.cmdWr && secondByte && cmdType == CMD_RD_SETUP)
        setupPend <= 1'b1;
      else if (fetch)
        setupPend <= 1'b0;

      capturePend <= fetch;
    end
  end

  // R4: never read and write VRAM in one cycle
  p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.vramRd && ctl.vramWr));

  // R9: any status or data access resynchronises the command pair
  p_resync_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd || strb.statRd || strb.dataWr) |=> !secondByte);

  // R5: a read setup is followed by a fetch
  p_setup_fetch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdWr && secondByte && cmdType == CMD_RD_SETUP) |=> ctl.vramRd);

  // R5: each fetch is captured on the next cycle
  p_fetch_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.vramRd |=> ctl.capture);

  // R7: the illegal code produces no load and no register write
  p_illegal_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdWr && secondByte && cmdType == CMD_ILLEGAL) |=> !setupPend || $past(setupPend));

endmodule

// File: rtl/vdpHostDatapath.sv
`timescale 1ns/1ps
module vdpHostDatapath
  import vdpHostPkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int NUM_REGS    = 8,
  parameter bit PROG_STEP   = 1'b1,
  parameter int MODE_REG    = 0,
  parameter int MODE_BIT    = 1,
  parameter int STEP_REG    = 7,
  parameter int BLANK_REG   = 1,
  parameter int BLANK_BIT   = 6,
  localparam int HI_BITS    = ADDR_W - 8,
  localparam int SEL_W      = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctl,
  input  logic [7:0]            hostByte,
  input  logic [7:0]            statusIn,
  input  logic [7:0]            vramRdData,
  output logic [ADDR_W-1:0]     vramAddr,
  output logic [7:0]            vramWrData,
  output logic [7:0]            rdByte,
  output logic [NUM_REGS*8-1:0] ctrlRegs,
  output logic                  blankOut
);

  logic [7:0]        lowByte;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] stepVal;
  logic [7:0]        readLatch;
  logic [7:0]        regBank [NUM_REGS];
  logic [SEL_W-1:0]  regSel;

  assign regSel = hostByte[SEL_W-1:0];

  generate
    if (PROG_STEP) begin : g_progStep
      always_comb begin
        if (regBank[MODE_REG][MODE_BIT])
          stepVal = {{HI_BITS{regBank[STEP_REG][7]}}, regBank[STEP_REG]};
        else
          stepVal = ADDR_W'(1);
      end
    end else begin : g_fixedStep
      assign stepVal = ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowByte   <= '0;
      ptr       <= '0;
      readLatch <= '0;
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= '0;
    end else begin
      if (ctl.loadLow) lowByte <= hostByte;
      if (ctl.loadPtr)      ptr <= {hostByte[HI_BITS-1:0], lowByte};
      else if (ctl.advance) ptr <= ptr + stepVal;
      if (ctl.regWr)   regBank[regSel] <= lowByte;
      if (ctl.capture) readLatch <= vramRdData;
    end
  end

  assign vramAddr   = ptr;
  assign vramWrData = hostByte;

  always_comb begin
    if (ctl.driveData)      rdByte = ctl.capture ? vramRdData : readLatch;
    else if (ctl.driveStat) rdByte = statusIn;
    else                    rdByte = '0;
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
      assign ctrlRegs[g*8 +: 8] = regBank[g];
    end
  endgenerate

  assign blankOut = !regBank[BLANK_REG][BLANK_BIT];

  // R6: register writes leave the pointer alone
  p_reg_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.regWr && !ctl.advance) |=> $stable(ptr));

  // R3: the held first byte lands in the low pointer bits
  p_low_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadPtr |=> ptr[7:0] == $past(lowByte));

  // R8: a unit step from the top address wraps to zero
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.loadPtr && ptr == {ADDR_W{1'b1}} && stepVal == ADDR_W'(1))
    |=> ptr == '0);

  // R5: captured data reaches the latch
  p_latch_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> readLatch == $past(vramRdData));

endmodule

// File: rtl/vdpHostPort.sv
`timescale 1ns/1ps
module vdpHostPort
  import vdpHostPkg::*;
#(
  parameter int          ADDR_W       = 14,
  parameter int          NUM_REGS     = 8,
  parameter bit          PROG_STEP    = 1'b1,
  parameter logic [15:0] RD_DATA_ADDR = 16'h8800,
  parameter logic [15:0] RD_STAT_ADDR = 16'h8802,
  parameter logic [15:0] WR_DATA_ADDR = 16'h8C00,
  parameter logic [15:0] WR_CMD_ADDR  = 16'h8C02
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:0]           hostAddr,
  input  logic                  hostRd,
  input  logic                  hostWr,
  input  logic [15:0]           hostWrData,
  output logic [15:0]           hostRdData,
  output logic                  hostRdOe,
  input  logic [7:0]            statusIn,
  output logic [ADDR_W-1:0]     vramAddr,
  output logic                  vramRdEn,
  input  logic [7:0]            vramRdData,
  output logic                  vramWrEn,
  output logic [7:0]            vramWrData,
  output logic [NUM_REGS*8-1:0] ctrlRegs,
  output logic                  blankOut
);

  hostStrobes_t strb;
  dpCtrl_t      ctl;
  logic [7:0]   rdByte;
  logic         unusedLowLane;

  assign unusedLowLane = ^hostWrData[7:0];

  vdpHostDecode #(
    .HOST_AW(16), .RD_DATA_ADDR(RD_DATA_ADDR), .RD_STAT_ADDR(RD_STAT_ADDR),
    .WR_DATA_ADDR(WR_DATA_ADDR), .WR_CMD_ADDR(WR_CMD_ADDR)
  ) u_decode (
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr), .strb(strb)
  );

  vdpHostCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdBits(hostWrData[15:14]), .ctl(ctl)
  );

  vdpHostDatapath #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .PROG_STEP(PROG_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostByte(hostWrData[15:8]),
    .statusIn(statusIn), .vramRdData(vramRdData), .vramAddr(vramAddr),
    .vramWrData(vramWrData), .rdByte(rdByte), .ctrlRegs(ctrlRegs),
    .blankOut(blankOut)
  );

  assign hostRdOe   = ctl.driveData || ctl.driveStat;
  assign hostRdData = {rdByte, 8'h00};
  assign vramRdEn   = ctl.vramRd;
  assign vramWrEn   = ctl.vramWr;

  // R1: the bus is driven only during a decoded read
  p_drive_only_on_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    hostRdOe |-> hostRd);

  // R2: the low lane is never driven
  p_low_lane_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostRdData[7:0] == 8'h00);

endmodule

// File: tb/sim_vdpHostPort.sv
`timescale 1ns/1ps
module sim_vdpHostPort;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] hostAddr = '0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        hostRdOe;
  logic [7:0]  statusIn = 8'hC3;
  logic [13:0] vramAddr;
  logic        vramRdEn;
  logic [7:0]  vramRdData;
  logic        vramWrEn;
  logic [7:0]  vramWrData;
  logic [63:0] ctrlRegs;
  logic        blankOut;

  always #10 clk = ~clk;

  vdpHostPort u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostRdOe(hostRdOe),
    .statusIn(statusIn), .vramAddr(vramAddr), .vramRdEn(vramRdEn),
    .vramRdData(vramRdData), .vramWrEn(vramWrEn), .vramWrData(vramWrData),
    .ctrlRegs(ctrlRegs), .blankOut(blankOut)
  );

  // VRAM model: 1 KiB aliased window, read data one cycle after request
  logic [7:0]  mem [0:1023];
  logic [7:0]  rdQ = '0;
  logic [13:0] lastWrAddr = '0;
  logic [7:0]  lastWrData = '0;
  int          wrCount = 0;
  assign vramRdData = rdQ;

  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    if (vramWrEn) begin
      mem[vramAddr[9:0]] <= vramWrData;
      lastWrAddr <= vramAddr;
      lastWrData <= vramWrData;
      wrCount    <= wrCount + 1;
    end
    if (vramRdEn) rdQ <= mem[vramAddr[9:0]];
  end

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = {d, ~d}; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; hostAddr = '0;
  endtask

  task automatic hread(input logic [15:0] a, output logic [15:0] dat, output logic oe);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #5;
    dat = hostRdData; oe = hostRdOe;
    @(negedge clk);
    hostRd = 1'b0; hostAddr = '0;
  endtask

  // {isRead, address, byte to write, expected byte}
  localparam int NV = 17;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {1'b0, 16'h8C02, 8'h23, 8'h00},   // R3 low byte 0x23
    {1'b0, 16'h8C02, 8'h41, 8'h00},   // R4 write setup 0x0123
    {1'b0, 16'h8C00, 8'hAA, 8'h00},
    {1'b0, 16'h8C00, 8'hBB, 8'h00},
    {1'b0, 16'h8C00, 8'hCC, 8'h00},
    {1'b0, 16'h8C02, 8'h23, 8'h00},
    {1'b0, 16'h8C02, 8'h01, 8'h00},   // R5 read setup 0x0123
    {1'b1, 16'h8800, 8'h00, 8'hAA},
    {1'b1, 16'h8800, 8'h00, 8'hBB},
    {1'b1, 16'h8800, 8'h00, 8'hCC},
    {1'b0, 16'h8C02, 8'h55, 8'h00},
    {1'b0, 16'h8C02, 8'h83, 8'h00},   // R6 reg3 = 0x55
    {1'b1, 16'h8800, 8'h00, 8'h7C},   // 0x126
    {1'b1, 16'h8800, 8'h00, 8'h7D},   // 0x127
    {1'b0, 16'h8C02, 8'h00, 8'h00},
    {1'b0, 16'h8C02, 8'hC0, 8'h00},   // R7 illegal code
    {1'b1, 16'h8800, 8'h00, 8'h72}    // 0x128
  };

  initial begin
    logic [15:0] d;
    logic        oe;
    int          w0;

    repeat (3) @(negedge clk);
    // reset state
    chk("R12 regs reset", {31'b0, |ctrlRegs}, 32'd0);
    chk("R11 blank after reset", {31'b0, blankOut}, 32'd1);
    chk("R1 bus idle after reset", {30'b0, hostRdOe, vramWrEn}, 32'd0);
    rstN = 1'b1;

    // vector table: R2..R7
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) begin
        hread(VEC[i][31:16], d, oe);
        chk("R5 R2 data read", {16'b0, d}, {16'b0, VEC[i][7:0], 8'h00});
      end else begin
        hwrite(VEC[i][31:16], VEC[i][15:8]);
      end
    end
    hread(16'h8800, d, oe);
    chk("R7 pointer kept after illegal code", {16'b0, d}, {16'b0, 8'h73, 8'h00});
    chk("R6 register 3 contents", {24'b0, ctrlRegs[31:24]}, 32'h55);

    // R10 status, R1 unmapped and write-only reads
    hread(16'h8802, d, oe);
    chk("R10 status read", {15'b0, oe, d}, {15'b0, 1'b1, 8'hC3, 8'h00});
    hread(16'h8C00, d, oe);
    chk("R1 read of write port", {15'b0, oe, d}, 32'd0);
    hread(16'h8804, d, oe);
    chk("R1 read of unmapped address", {15'b0, oe, d}, 32'd0);
    hread(16'h8800, d, oe);
    chk("R1 pointer not moved by stray reads", {16'b0, d}, {16'b0, 8'h70, 8'h00});
    w0 = wrCount;
    hwrite(16'h8C04, 8'h99);
    chk("R1 write to unmapped address", wrCount, w0);

    // R8 wrap
    hwrite(16'h8C02, 8'hFF); hwrite(16'h8C02, 8'h7F);
    hwrite(16'h8C00, 8'h11);
    chk("R8 write at top address", {18'b0, lastWrAddr}, 32'h3FFF);
    hwrite(16'h8C00, 8'h22);
    chk("R8 wrap to zero", {18'b0, lastWrAddr}, 32'h0000);

    // R9 resync by status read
    hwrite(16'h8C02, 8'h34);
    hread(16'h8802, d, oe);
    hwrite(16'h8C02, 8'h00); hwrite(16'h8C02, 8'h41);
    hwrite(16'h8C00, 8'h66);
    chk("R9 resync after status read", {18'b0, lastWrAddr}, 32'h0100);
    // R9 resync by data write
    hwrite(16'h8C02, 8'h77);
    hwrite(16'h8C00, 8'h10);
    hwrite(16'h8C02, 8'h00); hwrite(16'h8C02, 8'h42);
    hwrite(16'h8C00, 8'h67);
    chk("R9 resync after data write", {18'b0, lastWrAddr}, 32'h0200);

    // R11 blanking
    hwrite(16'h8C02, 8'h40); hwrite(16'h8C02, 8'h81);
    chk("R11 display on", {31'b0, blankOut}, 32'd0);
    hwrite(16'h8C02, 8'h00); hwrite(16'h8C02, 8'h81);
    chk("R11 display blanked", {31'b0, blankOut}, 32'd1);
    hwrite(16'h8C02, 8'h00); hwrite(16'h8C02, 8'h43);
    hwrite(16'h8C00, 8'h5C);
    chk("R11 access while blanked", {10'b0, lastWrAddr, lastWrData}, {10'b0, 14'h0300, 8'h5C});

    // R12 programmable step of -2
    hwrite(16'h8C02, 8'hFE); hwrite(16'h8C02, 8'h87);
    hwrite(16'h8C02, 8'h02); hwrite(16'h8C02, 8'h80);
    hwrite(16'h8C02, 8'h10); hwrite(16'h8C02, 8'h40);
    hwrite(16'h8C00, 8'hA1);
    chk("R12 first stepped write", {18'b0, lastWrAddr}, 32'h0010);
    hwrite(16'h8C00, 8'hA2);
    chk("R12 step -2", {18'b0, lastWrAddr}, 32'h000E);
    hwrite(16'h8C00, 8'hA3);
    chk("R12 step -2 again", {18'b0, lastWrAddr}, 32'h000C);
    hwrite(16'h8C02, 8'h00); hwrite(16'h8C02, 8'h80);
    hwrite(16'h8C02, 8'h20); hwrite(16'h8C02, 8'h40);
    hwrite(16'h8C00, 8'hB1); hwrite(16'h8C00, 8'hB2);
    chk("R12 unit step restored", {18'b0, lastWrAddr}, 32'h0021);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule